// File: doc/BRIEF.md
# Reset Qualifier with Emulation-Mode Entry

This block sits between the raw, asynchronous, active-high reset pin of a small controller and the rest of the chip. It brings the pin into the oscillator clock domain and counts how long the pin stays high. Only after the pin has held for a full qualification window of 24 oscillator clocks does the block raise its internal reset. Shorter pulses and glitches are discarded.

While the internal reset is active, the block also watches two strap pins: the address-latch strobe and the program-store strobe, each brought in as a sensed level. When the internal reset drops, the block samples both straps in that same cycle. If the address-latch level is low and the program-store level is high, the block latches an emulation mode. In that mode the block puts the first port in a floating state and drives every other port, and both strobes, with weak pull-ups only, so an external tester can take over the board.

The emulation mode stays in place until a later qualified reset clears it. A release that does not meet the strap condition then leaves the block in normal operation.

Top module: `rst_emu_ctrl`

## Requirements
- R1: The reset pin and both strap pins pass through a two-stage synchronizer. `core_rst` rises only after the synchronized pin has been high for 24 consecutive clocks. If the pin is first sampled high at clock edge 0, `core_rst` is still 0 after edge 24 and is 1 after edge 25.
- R2: Any clock in which the synchronized pin is low restarts the count from zero. A high pulse shorter than the window never raises `core_rst`.
- R3: `core_rst` stays high while the pin stays high. If the pin is first sampled low at edge 0, `core_rst` is still 1 after edge 1 and is 0 after edge 2.
- R4: In the edge where `core_rst` falls, `emu_mode` loads 1 when the synchronized address-latch level is 0 and the synchronized program-store level is 1. Otherwise it loads 0.
- R5: If the address-latch strap is high at release, no emulation mode is entered, even when it was low earlier during reset.
- R6: Outside a qualified reset, `emu_mode` keeps its value. A reset-pin pulse too short to qualify leaves it unchanged.
- R7: A qualified reset clears `emu_mode` one edge after `core_rst` rises, while the pin is still high.
- R8: Drive codes are 00 normal, 01 weak pull-up and 10 float. Port n uses `port_drv[2n+1:2n]`. With `emu_mode`=1, port 0 is 10, and ports 1 to 3, `ale_drv` and `psen_drv` are 01. With `emu_mode`=0, all codes are 00.
- R9: If the program-store strap is low at release, no emulation mode is entered, whatever the address-latch level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw asynchronous active-high reset pin |
| ale_pin | input | 1 | Sensed level of the address-latch strobe pin |
| psen_pin | input | 1 | Sensed level of the program-store strobe pin |
| core_rst | output | 1 | Qualified internal reset |
| emu_mode | output | 1 | Emulation (tri-state) mode flag |
| port_drv | output | 8 | 2-bit drive code per port, port n at [2n+1:2n] |
| ale_drv | output | 2 | Drive code for the address-latch pad |
| psen_drv | output | 2 | Drive code for the program-store pad |

## Verification
The assertions check four things on every cycle:
- a qualified reset only begins while the synchronized pin is high;
- a low pin is always followed by a dropped reset;
- the emulation flag never moves outside reset and only rises after the strap pattern;
- in emulation mode, the pad codes match the flag.

The exact 24-clock qualification window, the restart after a one-cycle glitch, the two-edge release latency, and each of the strap combinations at release (late address-latch rise, low program-store, valid request) need the bench's timed scenarios with cycle-stamped expectations.

// File: rtl/rst_emu_pkg.sv
package rst_emu_pkg;

    typedef enum logic [1:0] {
        DRV_NORMAL = 2'b00,
        DRV_WEAK   = 2'b01,
        DRV_FLOAT  = 2'b10
    } drive_e;

    typedef struct packed {
        logic rst;
        logic ale;
        logic psen;
    } pins_t;

    // Drive code for port idx given the emulation flag.
    function automatic drive_e port_drive(int unsigned idx, logic emu);
        if (!emu)
            return DRV_NORMAL;
        return (idx == 0) ? DRV_FLOAT : DRV_WEAK;
    endfunction

    // Strap condition sampled at reset release.
    function automatic logic strap_requests_emu(logic ale_lvl, logic psen_lvl);
        return !ale_lvl && psen_lvl;
    endfunction

endpackage

// File: rtl/rst_emu_sync.sv
module rst_emu_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rst_emu_qual.sv
module rst_emu_qual #(
    parameter int HOLD_CYCLES = 24
) (
    input  logic clk,
    input  logic pin_s,
    output logic qual,
    output logic release_p
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD_CYCLES);

    logic [CW-1:0] hold_cnt;

    // Saturating count of consecutive high cycles; restarts on any low.
    always_ff @(posedge clk) begin
        if (!pin_s)
            hold_cnt <= '0;
        else if (hold_cnt != HOLD_C)
            hold_cnt <= hold_cnt + 1'b1;
    end

    assign qual      = (hold_cnt == HOLD_C);
    assign release_p = qual && !pin_s;

    AST_QUAL_NEEDS_PIN: assert property (@(posedge clk) disable iff (!pin_s)
        $rose(qual) |-> $past(pin_s)); // R1
    AST_LOW_DROPS_QUAL: assert property (@(posedge clk) disable iff (pin_s)
        !pin_s |=> !qual); // R2
    AST_FALL_ONLY_LOW: assert property (@(posedge clk) disable iff (pin_s)
        $fell(qual) |-> !pin_s); // R3
endmodule

// File: rtl/rst_emu_strap.sv
module rst_emu_strap
    import rst_emu_pkg::*;
(
    input  logic clk,
    input  logic pin_s,
    input  logic qual,
    input  logic release_p,
    input  logic ale_s,
    input  logic psen_s,
    output logic emu
);
    always_ff @(posedge clk) begin
        if (release_p)
            emu <= strap_requests_emu(ale_s, psen_s);
        else if (qual)
            emu <= 1'b0;
    end

    AST_EMU_NEEDS_STRAP: assert property (@(posedge clk) disable iff (pin_s)
        $rose(emu) |-> $past(!ale_s && psen_s)); // R4
    AST_EMU_STEADY: assert property (@(posedge clk) disable iff (qual)
        !$past(qual) |-> $stable(emu)); // R6
    AST_EMU_CLEARED: assert property (@(posedge clk) disable iff (!pin_s)
        qual && pin_s |=> !emu); // R7
endmodule

// File: rtl/rst_emu_pads.sv
module rst_emu_pads
    import rst_emu_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                   emu,
    output logic [2*NUM_PORTS-1:0] port_drv,
    output logic [1:0]             ale_drv,
    output logic [1:0]             psen_drv
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_drv[2*p +: 2] = port_drive(p, emu);
    end

    assign ale_drv  = emu ? DRV_WEAK : DRV_NORMAL;
    assign psen_drv = emu ? DRV_WEAK : DRV_NORMAL;
endmodule

// File: rtl/rst_emu_ctrl.sv
module rst_emu_ctrl
    import rst_emu_pkg::*;
#(
    parameter int HOLD_CYCLES = 24,
    parameter int SYNC_STAGES = 2,
    parameter int NUM_PORTS   = 4
) (
    input  logic                   clk_osc,
    input  logic                   rst_pin,
    input  logic                   ale_pin,
    input  logic                   psen_pin,
    output logic                   core_rst,
    output logic                   emu_mode,
    output logic [2*NUM_PORTS-1:0] port_drv,
    output logic [1:0]             ale_drv,
    output logic [1:0]             psen_drv
);
    localparam int PW = $bits(pins_t);

    pins_t raw_pins, sync_pins;
    logic  qual, release_p;

    assign raw_pins = '{rst: rst_pin, ale: ale_pin, psen: psen_pin};

    rst_emu_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_osc),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    rst_emu_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
        .clk       (clk_osc),
        .pin_s     (sync_pins.rst),
        .qual      (qual),
        .release_p (release_p)
    );

    rst_emu_strap u_strap (
        .clk       (clk_osc),
        .pin_s     (sync_pins.rst),
        .qual      (qual),
        .release_p (release_p),
        .ale_s     (sync_pins.ale),
        .psen_s    (sync_pins.psen),
        .emu       (emu_mode)
    );

    rst_emu_pads #(.NUM_PORTS(NUM_PORTS)) u_pads (
        .emu      (emu_mode),
        .port_drv (port_drv),
        .ale_drv  (ale_drv),
        .psen_drv (psen_drv)
    );

    assign core_rst = qual;

    AST_EMU_PADS: assert property (@(posedge clk_osc) disable iff (core_rst)
        emu_mode |-> (port_drv[1:0] == 2'b10) && (ale_drv == 2'b01) && (psen_drv == 2'b01)); // R8
endmodule

// File: tb/rst_emu_ctrl_tb.sv
`timescale 1ns/1ps
module rst_emu_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_pin = 1'b0, ale_pin = 1'b1, psen_pin = 1'b1;
    logic       core_rst, emu_mode;
    logic [7:0] port_drv;
    logic [1:0] ale_drv, psen_drv;

    int cyc = 0, checks = 0, errors = 0;

    typedef struct {
        int    cyc;
        logic  rst;
        logic  emu;
        string tag;
    } exp_t;
    exp_t sb[$];

    rst_emu_ctrl u_dut (
        .clk_osc (clk), .rst_pin (rst_pin), .ale_pin (ale_pin), .psen_pin (psen_pin),
        .core_rst (core_rst), .emu_mode (emu_mode), .port_drv (port_drv),
        .ale_drv (ale_drv), .psen_drv (psen_drv)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int dc, logic r, logic e, string tag);
        exp_t it;
        it.cyc = cyc + dc; it.rst = r; it.emu = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expectations whose cycle has arrived (R8 pad codes derived here).
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t it;
            logic [7:0] e_pd;
            logic [1:0] e_sd;
            it = sb.pop_front();
            e_pd = it.emu ? 8'b01_01_01_10 : 8'b0;
            e_sd = it.emu ? 2'b01 : 2'b00;
            checks++;
            if (it.cyc != cyc || core_rst !== it.rst || emu_mode !== it.emu ||
                port_drv !== e_pd || ale_drv !== e_sd || psen_drv !== e_sd) begin
                errors++;
                $display("FAIL %s cyc=%0d: rst=%b emu=%b pd=%b ad=%b sd=%b, expected cyc=%0d rst=%b emu=%b pd=%b ad=%b sd=%b",
                         it.tag, cyc, core_rst, emu_mode, port_drv, ale_drv, psen_drv,
                         it.cyc, it.rst, it.emu, e_pd, e_sd, e_sd);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        expect_at(1, 1'b0, 1'b0, "R1 idle");
        idle(3);
        // R1: qualification window, no strap
        rst_pin = 1'b1; ale_pin = 1'b1; psen_pin = 1'b1;
        expect_at(25, 1'b0, 1'b0, "R1");
        expect_at(26, 1'b1, 1'b0, "R1");
        idle(30);
        // R3: release latency, R4 without strap
        rst_pin = 1'b0;
        expect_at(2, 1'b1, 1'b0, "R3");
        expect_at(3, 1'b0, 1'b0, "R3");
        expect_at(6, 1'b0, 1'b0, "R4");
        idle(8);
        // R2: short pulse then one-cycle glitch restarts count
        rst_pin = 1'b1;
        expect_at(10, 1'b0, 1'b0, "R2");
        idle(20);
        rst_pin = 1'b0;
        idle(1);
        rst_pin = 1'b1;
        expect_at(25, 1'b0, 1'b0, "R2");
        expect_at(26, 1'b1, 1'b0, "R2");
        idle(28);
        // R4/R8: valid strap at release
        ale_pin = 1'b0; psen_pin = 1'b1;
        idle(3);
        rst_pin = 1'b0;
        expect_at(2, 1'b1, 1'b0, "R3");
        expect_at(3, 1'b0, 1'b1, "R4");
        expect_at(8, 1'b0, 1'b1, "R8");
        idle(10);
        // R6: short pulse leaves emulation in place
        rst_pin = 1'b1; ale_pin = 1'b1;
        expect_at(5, 1'b0, 1'b1, "R6");
        expect_at(10, 1'b0, 1'b1, "R6");
        idle(10);
        rst_pin = 1'b0;
        expect_at(5, 1'b0, 1'b1, "R6");
        idle(8);
        // R7: qualified reset clears emulation
        rst_pin = 1'b1; ale_pin = 1'b1; psen_pin = 1'b1;
        expect_at(26, 1'b1, 1'b1, "R7");
        expect_at(27, 1'b1, 1'b0, "R7");
        idle(30);
        // R5: strap requested, then ALE high at release
        ale_pin = 1'b0; psen_pin = 1'b1;
        idle(2);
        rst_pin = 1'b0; ale_pin = 1'b1;
        expect_at(3, 1'b0, 1'b0, "R5");
        idle(8);
        // R9: PSEN low at release
        rst_pin = 1'b1; ale_pin = 1'b0; psen_pin = 1'b0;
        idle(30);
        rst_pin = 1'b0;
        expect_at(3, 1'b0, 1'b0, "R9");
        idle(8);
        // R4: enter emulation again from normal
        rst_pin = 1'b1; ale_pin = 1'b0; psen_pin = 1'b1;
        idle(30);
        rst_pin = 1'b0;
        expect_at(3, 1'b0, 1'b1, "R4");
        expect_at(4, 1'b0, 1'b1, "R8");
        idle(10);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d pending, expected 0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule